// File: doc/BRIEF.md
# Byte-Sliced Quad-Bank Data Memory

This block is the data memory of a core that retires one instruction per clock. It stores and returns bytes, halfwords and words at any byte address. Accesses that straddle a 32-bit word boundary are included, and every access takes a single cycle. No access is ever split into two cycles, and no store ever needs a read-modify-write.

Storage is four byte-wide synchronous RAM banks. Bank `b` holds every byte whose address has `b` in its two low bits. Each access works out a row for each bank. A bank whose lane index is below the byte offset uses the next row, and every other bank uses the current row. Store data is rotated into the lanes, and only the lanes the access covers are enabled. The lane offset, size and extension mode are registered alongside the read. In the next cycle the returned lanes are rotated back and extended.

The array can be preloaded at elaboration from a packed byte-image parameter.

Top module: `dmem_quad`

## Requirements
- R1: A store of size code 00 (byte), 01 (halfword) or 10 (word) writes exactly 1, 2 or 4 consecutive bytes. The first byte is at `addr_i` and gets `wdata_i[7:0]`, and each following byte takes the next higher byte of `wdata_i`. Addresses wrap from the top of the address space to 0. All other bytes keep their values.
- R2: Bank `b` holds the bytes whose address modulo 4 equals `b`. Accesses at any of the four alignments, including ones crossing a word boundary, complete in one cycle.
- R3: Size code 11 performs no access. Neither the memory nor `rdata_o` changes, whatever the value of `we_i`.
- R4: The result of a load appears on `rdata_o` after the next rising clock edge. Byte `k` of the result is the byte at address `addr_i+k`, wrapping at the top of the address space. Loads and stores may be issued in every cycle.
- R5: For a byte or halfword load, `uns_i`=1 fills the upper bits with zeros. With `uns_i`=0 they are filled with copies of bit 7 or bit 15 respectively. For a word load `uns_i` has no effect.
- R6: In a cycle with a store or no access, `rdata_o` holds the result of the last load.
- R7: A load issued in the cycle right after a store to overlapping bytes returns the newly stored bytes.
- R8: While `rst_ni` is low, and after its release until the first load, `rdata_o` is zero.
- R9: Before any store, byte `i` of the memory equals `INIT_IMAGE[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 none |
| we_i | input | 1 | 1 = store, 0 = load |
| wdata_i | input | 32 | Store data, least significant byte at `addr_i` |
| uns_i | input | 1 | 1 = zero-extend, 0 = sign-extend for byte and halfword loads |
| rdata_o | output | 32 | Load result, registered |

## Verification
Two of the block's functions can meet in the same pair of cycles: a store that commits at a clock edge, and a load that reads those same bytes from the row registers at the very next edge.

The bench provokes this by following every store of each size and alignment with an immediate load. Some of those loads are shifted so that they straddle both written and untouched bytes, near address 0 and at the top of the address space. A long random stream of back-to-back mixed accesses provokes it further.

Each load result is judged against a byte-array model that the driver updates as it issues each store. This makes a stale read or a write into the wrong row visible as a byte mismatch. The model also checks that `rdata_o` holds between loads.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } size_e;

  function automatic logic [2:0] size_bytes(input size_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dmem_lane_ctrl.sv
`timescale 1ns/1ps
module dmem_lane_ctrl
  import dmem_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ROW_W+1:0]                  addr_i,
  input  size_e                             size_i,
  input  logic                              we_i,
  input  logic [31:0]                       wdata_i,
  output logic [LANES-1:0][ROW_W-1:0]       row_o,
  output logic [LANES-1:0]                  bank_we_o,
  output logic [LANES-1:0]                  bank_re_o,
  output logic [LANES-1:0][7:0]             bank_wd_o,
  output logic [1:0]                        off_o
);
  logic [1:0]       off;
  logic [ROW_W-1:0] base;
  logic [ROW_W-1:0] base_p1;
  logic [2:0]       nbytes;
  logic             active;

  assign off     = addr_i[1:0];
  assign base    = addr_i[ROW_W+1:2];
  assign base_p1 = base + ROW_W'(1);   // wraps at the top row
  assign nbytes  = size_bytes(size_i);
  assign active  = (nbytes != 3'd0);
  assign off_o   = off;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0] rel;     // byte index within the access served by this lane
    logic       covered;
    assign rel          = 2'(b) - off;
    assign covered      = ({1'b0, rel} < nbytes);
    assign row_o[b]     = (2'(b) < off) ? base_p1 : base;
    assign bank_we_o[b] = active & we_i & covered;
    assign bank_re_o[b] = active & ~we_i & covered;
    assign bank_wd_o[b] = wdata_i[8*rel +: 8];
  end

  logic [2:0] adv_cnt;
  always_comb begin
    adv_cnt = '0;
    for (int b = 0; b < LANES; b++)
      if (row_o[b] != base) adv_cnt = adv_cnt + 3'd1;
  end

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_NONE) |-> (bank_we_o == '0 && bank_re_o == '0));

  assert_lane_cnt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i != SZ_NONE) |-> ($countones(bank_we_o | bank_re_o) == int'(size_bytes(size_i))));

  assert_rw_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|bank_we_o) && (|bank_re_o)));

  assert_row_adv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_cnt == {1'b0, addr_i[1:0]});
endmodule

// File: rtl/dmem_bank.sv
`timescale 1ns/1ps
module dmem_bank #(
  parameter int ROW_W = 8,
  localparam int ROWS = 2 ** ROW_W,
  parameter logic [8*ROWS-1:0] INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [7:0]       wd_i,
  output logic [7:0]       rd_o
);
  logic [7:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) mem[r] = INIT[8*r +: 8];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[row_i] <= wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_o <= '0;
    else if (re_i) rd_o <= mem[row_i];
  end
endmodule

// File: rtl/dmem_load_fmt.sv
`timescale 1ns/1ps
module dmem_load_fmt
  import dmem_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [1:0]            off_i,
  input  size_e                 size_i,
  input  logic                  uns_i,
  input  logic [LANES-1:0][7:0] bank_rd_i,
  output logic [31:0]           rdata_o
);
  logic [1:0] off_q;
  size_e      size_q;
  logic       uns_q;
  logic [31:0] rot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      size_q <= SZ_WORD;
      uns_q  <= 1'b1;
    end else if (cap_i) begin
      off_q  <= off_i;
      size_q <= size_i;
      uns_q  <= uns_i;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) rot[8*k +: 8] = bank_rd_i[2'(k) + off_q];
    case (size_q)
      SZ_BYTE: rdata_o = {{24{~uns_q & rot[7]}},  rot[7:0]};
      SZ_HALF: rdata_o = {{16{~uns_q & rot[15]}}, rot[15:0]};
      default: rdata_o = rot;
    endcase
  end

  assert_zext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uns_q && size_q == SZ_BYTE) |-> (rdata_o[31:8] == '0));

  assert_sext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uns_q && size_q == SZ_HALF) |-> (rdata_o[31:16] == {16{rdata_o[15]}}));
endmodule

// File: rtl/dmem_quad.sv
`timescale 1ns/1ps
module dmem_quad
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [8*(2**ADDR_W)-1:0] INIT_IMAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              uns_i,
  output logic [31:0]       rdata_o
);
  localparam int ROW_W = ADDR_W - 2;
  localparam int ROWS  = 2 ** ROW_W;

  function automatic logic [8*ROWS-1:0] bank_slice(input int b);
    logic [8*ROWS-1:0] s;
    for (int r = 0; r < ROWS; r++) s[8*r +: 8] = INIT_IMAGE[8*(LANES*r + b) +: 8];
    return s;
  endfunction

  size_e                         size;
  logic [LANES-1:0][ROW_W-1:0]   rows;
  logic [LANES-1:0]              bank_we;
  logic [LANES-1:0]              bank_re;
  logic [LANES-1:0][7:0]         bank_wd;
  logic [LANES-1:0][7:0]         bank_rd;
  logic [1:0]                    off;
  logic                          ld;
  logic                          seen_q;

  assign size = size_e'(size_i);
  assign ld   = (size != SZ_NONE) && !we_i;

  dmem_lane_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .size_i    (size),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .row_o     (rows),
    .bank_we_o (bank_we),
    .bank_re_o (bank_re),
    .bank_wd_o (bank_wd),
    .off_o     (off)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [8*ROWS-1:0] B_INIT = bank_slice(b);
    dmem_bank #(.ROW_W(ROW_W), .INIT(B_INIT)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .row_i  (rows[b]),
      .we_i   (bank_we[b]),
      .re_i   (bank_re[b]),
      .wd_i   (bank_wd[b]),
      .rd_o   (bank_rd[b])
    );
  end

  dmem_load_fmt u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (ld),
    .off_i     (off),
    .size_i    (size),
    .uns_i     (uns_i),
    .bank_rd_i (bank_rd),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(seen_q) && !$past(ld)) |-> $stable(rdata_o));
endmodule

// File: tb/sim_dmem_quad.sv
`timescale 1ns/1ps
module sim_dmem_quad;
  localparam int AW   = 8;
  localparam int NB   = 1 << AW;
  localparam int MASK = NB - 1;

  function automatic logic [8*NB-1:0] mk_img();
    logic [8*NB-1:0] v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = 8'((i * 37 + 11) & 255);
    return v;
  endfunction
  localparam logic [8*NB-1:0] IMG = mk_img();

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr_s;
  logic [1:0]    size_s;
  logic          we_s;
  logic [31:0]   wdata_s;
  logic          uns_s;
  logic [31:0]   rdata;

  dmem_quad #(.ADDR_W(AW), .INIT_IMAGE(IMG)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .addr_i  (addr_s),
    .size_i  (size_s),
    .we_i    (we_s),
    .wdata_i (wdata_s),
    .uns_i   (uns_s),
    .rdata_o (rdata)
  );

  always #2 clk = ~clk;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t        q[$];
  logic [7:0]  model [NB];
  int          total = 0;
  int          bad = 0;
  logic [31:0] last_exp = '0;
  bit          done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nb_of(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_load(int a, logic [1:0] sz, logic uns);
    logic [31:0] v = '0;
    int n = nb_of(sz);
    for (int k = 0; k < n; k++) v[8*k +: 8] = model[(a + k) & MASK];
    if (!uns && n == 1) v[31:8]  = {24{v[7]}};
    if (!uns && n == 2) v[31:16] = {16{v[15]}};
    return v;
  endfunction

  // driver: presents one access per cycle and records what it should produce
  task automatic acc(int a, logic [1:0] sz, logic we, logic [31:0] wd, logic uns, string tag);
    @(negedge clk);
    addr_s = AW'(a & MASK); size_s = sz; we_s = we; wdata_s = wd; uns_s = uns;
    if (sz != 2'b11) begin
      if (we) begin
        for (int k = 0; k < nb_of(sz); k++) model[(a + k) & MASK] = wd[8*k +: 8];
      end else begin
        q.push_back('{exp_load(a, sz, uns), tag});
      end
    end
  endtask

  // monitor: judges the output after every edge
  initial begin
    forever begin
      bit   ld;
      exp_t e;
      @(posedge clk);
      ld = rst_ni && (size_s != 2'b11) && !we_s;
      #1;
      if (rst_ni && !done) begin
        if (ld) begin
          if (q.size() == 0) begin
            chk("R4_queue_empty", 32'd1, 32'd0);
          end else begin
            e = q.pop_front();
            chk(e.tag, rdata, e.v);
            last_exp = e.v;
          end
        end else begin
          chk("R6", rdata, last_exp);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bases[12] = '{0, 1, 2, 3, 101, 102, 103, 104, NB-4, NB-3, NB-2, NB-1};
    for (int i = 0; i < NB; i++) model[i] = IMG[8*i +: 8];
    rst_ni = 1'b0; addr_s = '0; size_s = 2'b11; we_s = 1'b0; wdata_s = '0; uns_s = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", rdata, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8", rdata, 32'd0);
    @(negedge clk);
    chk("R8", rdata, 32'd0);

    // preload image, all rows and a few unaligned
    for (int a = 0; a < NB; a += 4) acc(a, 2'b10, 1'b0, '0, 1'b1, "R9");
    for (int a = NB-5; a < NB; a++) acc(a, 2'b10, 1'b0, '0, 1'b0, "R9");

    // every size at every alignment, incl. top wrap; load right after store
    for (int sz = 0; sz < 3; sz++) begin
      for (int i = 0; i < 12; i++) begin
        acc(bases[i], 2'(sz), 1'b1, $urandom, 1'b0, "R1");
        acc(bases[i], 2'(sz), 1'b0, '0, 1'b0, "R7");
        acc(bases[i], 2'(sz), 1'b0, '0, 1'b1, "R5");
        acc(bases[i] - 2, 2'b10, 1'b0, '0, 1'b1, "R2");
        acc(bases[i] + 2, 2'b10, 1'b0, '0, 1'b1, "R1");
      end
    end

    // explicit sign cases
    acc(50, 2'b10, 1'b1, 32'hFF80_7F80, 1'b0, "R1");
    acc(50, 2'b00, 1'b0, '0, 1'b0, "R5");   // 0x80 -> FFFFFF80
    acc(50, 2'b00, 1'b0, '0, 1'b1, "R5");   // 0x80 -> 00000080
    acc(52, 2'b01, 1'b0, '0, 1'b0, "R5");   // FF80 -> FFFFFF80
    acc(50, 2'b01, 1'b0, '0, 1'b0, "R5");   // 7F80 -> 00007F80
    acc(51, 2'b10, 1'b0, '0, 1'b0, "R5");   // word unaffected by flag

    // no-access code with write enable must change nothing
    acc(60, 2'b10, 1'b0, '0, 1'b1, "R3");
    acc(60, 2'b11, 1'b1, 32'hDEAD_BEEF, 1'b0, "R3");
    acc(60, 2'b11, 1'b0, '0, 1'b0, "R3");
    acc(60, 2'b10, 1'b0, '0, 1'b1, "R3");

    // hold across store and idle cycles
    acc(70, 2'b10, 1'b0, '0, 1'b1, "R6");
    acc(70, 2'b10, 1'b1, 32'h1234_5678, 1'b0, "R6");
    acc(0, 2'b11, 1'b0, '0, 1'b0, "R6");
    acc(70, 2'b10, 1'b0, '0, 1'b1, "R7");

    // random back-to-back mix
    for (int n = 0; n < 3000; n++)
      acc(int'($urandom_range(0, NB-1)), 2'($urandom_range(0, 3)), 1'($urandom),
          $urandom, 1'($urandom), "R4");

    acc(0, 2'b11, 1'b0, '0, 1'b0, "R6");
    acc(0, 2'b11, 1'b0, '0, 1'b0, "R6");
    @(negedge clk);
    if (q.size() != 0) chk("R4_leftover", 32'(q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule